// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block lets a clocked system read and write an external asynchronous static RAM organised as 256K words of 16 bits. A request carries an address, a direction, write data and two byte-lane strobes. It is taken when the controller reports ready. The controller then runs the memory's active-low chip-enable, output-enable, write-enable and the two byte-lane enables. The number of clock cycles for each phase comes from parameters: the clock period and the memory's address and output-enable access times.

The data bus is carried as three separate signals: a driven value, a drive enable and a sampled input. The controller drives the bus only while the memory's outputs are disabled. When a write finishes, it keeps the address and data on the bus for one more clock after the write strobe rises. When no access is in flight, chip enable stays high so that the memory sits in standby. Each finished access gives a one-clock done pulse. For a read, the captured word appears in the same cycle as that pulse.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `memCeN`, `memOeN`, `memWeN`, `memUbN` and `memLbN` are all high, `memDqOe` is low, `rspDone` is low and `reqReady` is high.
- R2: During a read, `memCeN` and `memOeN` are low, `memWeN` is high, and both byte enables are low. `rspRdata` returns the whole 16-bit word stored at `reqAddr`.
- R3: Let rdWait = max(ceil(T_AA_PS/CLK_PS), ceil(T_OE_PS/CLK_PS), 1). A read samples `memDqIn` on the rdWait-th rising clock edge after the edge that accepts it, and `rspDone` is high in the cycle after that edge.
- R4: During a write, `memCeN` and `memWeN` are low and `memOeN` is high. `memWeN` stays low for wrWait = max(ceil(T_AA_PS/CLK_PS), 1) cycles. `memDqOut` stays stable and driven through the rising edge of `memWeN`.
- R5: `reqBe[0]` selects bits 7:0 and drives `memLbN` low. `reqBe[1]` selects bits 15:8 and drives `memUbN` low. A write changes only the selected bytes, and a write with `reqBe` = 2'b00 leaves the word unchanged.
- R6: `memDqOe` is high only while `memOeN` is high.
- R7: The chip-enable falls of two successive accesses are at least ceil(T_AA_PS/CLK_PS) cycles apart.
- R8: While `reqReady` is high, `memCeN` is high and both byte enables are high.
- R9: After `memWeN` rises, `memAddr`, `memDqOut` and `memDqOe` stay unchanged for one more clock. Then the bus is released and `rspDone` pulses wrWait+1 cycles after acceptance.
- R10: `rspDone` is high for exactly one clock per access. `rspRdata` keeps the last captured word until another read completes.
- R11: A request is taken on a rising edge where both `reqValid` and `reqReady` are high. `reqReady` is low from that edge until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte-lane write strobes; bit 0 selects the low byte |
| reqReady | output | 1 | Controller idle, so a request can be taken |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | DATA_W | Last read word |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |
| memDqOut | output | DATA_W | Value driven onto the data bus |
| memDqOe | output | 1 | Data bus drive enable |
| memDqIn | input | DATA_W | Value sampled from the data bus |

## Verification
The bench runs a small address space against a timing-aware memory model. That model returns the bit-inverted word if it is sampled before the address or output-enable access time has passed, so a read captured too early shows up as a data mismatch and a wrong latency count. The bench first writes every word in full with an address-derived pattern and reads it all back, which catches address and lane mapping faults. It then sweeps all four strobe combinations across the addresses, which separates correct lower-only, upper-only and no-lane writes from writes that touch the wrong byte. Timing monitors measure the write pulse width, the spacing between accesses and bus drive against output enable.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // take a new request
    logic isWrite;   // direction of the request being taken
    logic weRise;    // end the write pulse
    logic capture;   // sample read data
    logic finish;    // end the access, release memory
  } ctlStrobes_t;

  // ceiling division with a floor of one cycle
  function automatic int cycCeil(input int needPs, input int clkPs);
    int q;
    q = (needPs + clkPs - 1) / clkPs;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctlStrobes_t ctl
);

  localparam int WAIT_MAX = maxInt(RD_WAIT, WR_WAIT);
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_WAIT - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] waitCnt;
  logic             cntZero;

  assign cntZero  = (waitCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.load    = reqValid;
        ctl.isWrite = reqWrite;
      end
      ST_READ: begin
        ctl.capture = cntZero;
        ctl.finish  = cntZero;
      end
      ST_WRITE: begin
        ctl.weRise = cntZero;
      end
      ST_HOLD: begin
        ctl.finish = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= reqWrite ? ST_WRITE : ST_READ;
            waitCnt <= reqWrite ? WR_LOAD : RD_LOAD;
          end
        end
        ST_READ: begin
          if (cntZero) state <= ST_IDLE;
          else         waitCnt <= waitCnt - 1'b1;
        end
        ST_WRITE: begin
          if (cntZero) state <= ST_HOLD;
          else         waitCnt <= waitCnt - 1'b1;
        end
        ST_HOLD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic                memUbN,
  output logic                memLbN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] laneSel;
  logic [LANES-1:0] laneN;

  // reads open every lane, writes open only strobed lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneSel[g] = ctl.isWrite ? reqBe[g] : 1'b1;
  end

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      laneN    <= '1;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      rspRdata <= '0;
      rspDone  <= 1'b0;
    end else begin
      rspDone <= ctl.finish;
      if (ctl.load) begin
        memAddr <= reqAddr;
        memCeN  <= 1'b0;
        laneN   <= ~laneSel;
        if (ctl.isWrite) begin
          memWeN   <= 1'b0;
          memOeN   <= 1'b1;
          memDqOut <= reqWdata;
          memDqOe  <= 1'b1;
        end else begin
          memOeN <= 1'b0;
        end
      end
      if (ctl.weRise)  memWeN   <= 1'b1;
      if (ctl.capture) rspRdata <= memDqIn;
      if (ctl.finish) begin
        memCeN  <= 1'b1;
        memOeN  <= 1'b1;
        memWeN  <= 1'b1;
        laneN   <= '1;
        memDqOe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 4000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OE_PS   = 5000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                reqReady,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic                memUbN,
  output logic                memLbN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int AA_CYC  = cycCeil(T_AA_PS, CLK_PS);
  localparam int OE_CYC  = cycCeil(T_OE_PS, CLK_PS);
  localparam int RD_WAIT = maxInt(AA_CYC, OE_CYC);
  localparam int WR_WAIT = AA_CYC;

  ctlStrobes_t ctl;

  asram_ctrl_fsm #(
    .RD_WAIT (RD_WAIT),
    .WR_WAIT (WR_WAIT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  asram_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .rspDone  (rspDone),
    .rspRdata (rspRdata),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memUbN   (memUbN),
    .memLbN   (memLbN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int GAP_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  localparam int GW = $clog2(GAP_CYC + 1) + 1;

  logic          ceDly;
  logic [GW-1:0] gapCnt;

  // cycles since the last chip-enable fall, saturating at GAP_CYC
  always_ff @(posedge clk) begin
    if (rst) begin
      ceDly  <= 1'b1;
      gapCnt <= GW'(GAP_CYC);
    end else begin
      ceDly <= memCeN;
      if (!memCeN && ceDly)          gapCnt <= GW'(1);
      else if (gapCnt < GW'(GAP_CYC)) gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (memCeN && memOeN && memWeN && memUbN && memLbN && !memDqOe && !rspDone)); // R1
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (memWeN && !memCeN)); // R2
  AST_WE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (memDqOe && $stable(memDqOut) && $stable(memAddr))); // R4
  AST_BUS_SAFE: assert property (@(posedge clk) disable iff (rst)
    memDqOe |-> memOeN); // R6
  AST_ACCESS_GAP: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && ceDly) |-> (gapCnt >= GW'(GAP_CYC))); // R7
  AST_STANDBY: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCeN && memUbN && memLbN)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspDone |=> !rspDone); // R10

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .GAP_CYC (AA_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memUbN   (memUbN),
  .memLbN   (memLbN),
  .memDqOut (memDqOut),
  .memDqOe  (memDqOe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam int CLK_PS = 4000;
  localparam int TAA_PS = 10000;
  localparam int TOE_PS = 5000;
  localparam real TAA_NS = 10.0;
  localparam real TOE_NS = 5.0;
  // ceil(10/4)=3, ceil(5/4)=2 -> read waits 3, write pulse 3, write done at 4
  localparam int AA_CYC = (TAA_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_CYC = (TOE_PS + CLK_PS - 1) / CLK_PS;
  localparam int RD_LAT = (AA_CYC > OE_CYC) ? AA_CYC : OE_CYC;
  localparam int WR_LAT = AA_CYC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0] reqBe = 2'b00;
  logic reqReady, rspDone;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] memAddr;
  logic memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn = '0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  asram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .CLK_PS (CLK_PS),
    .T_AA_PS (TAA_PS), .T_OE_PS (TOE_PS)
  ) u_asram_ctrl (
    .clk (clk), .rst (rst), .reqValid (reqValid), .reqWrite (reqWrite),
    .reqAddr (reqAddr), .reqWdata (reqWdata), .reqBe (reqBe),
    .reqReady (reqReady), .rspDone (rspDone), .rspRdata (rspRdata),
    .memAddr (memAddr), .memCeN (memCeN), .memOeN (memOeN), .memWeN (memWeN),
    .memUbN (memUbN), .memLbN (memLbN), .memDqOut (memDqOut),
    .memDqOe (memDqOe), .memDqIn (memDqIn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model with access timing ----------------
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] expMem [NW];
  realtime tAddr = 0.0, tOe = 0.0, tWeFall = 0.0, tCeFall = -100.0;

  always @(memAddr) tAddr = $realtime;
  always @(negedge memOeN) tOe = $realtime;
  always @(negedge memWeN) tWeFall = $realtime;

  always @(negedge memCeN) begin
    if (!rst) begin
      check(($realtime - tCeFall) >= TAA_NS, "R7", "access spacing ps",
            32'(int'(($realtime - tCeFall) * 1000.0)), 32'(TAA_PS));
    end
    tCeFall = $realtime;
  end

  always @(posedge memWeN) begin
    if (!rst && !memCeN) begin
      check(($realtime - tWeFall) >= TAA_NS, "R4", "write pulse ps",
            32'(int'(($realtime - tWeFall) * 1000.0)), 32'(TAA_PS));
      check(memDqOe == 1'b1, "R4", "bus driven at WE rise", 32'(memDqOe), 32'd1);
      if (!memLbN) mem[memAddr][7:0]  = memDqOut[7:0];
      if (!memUbN) mem[memAddr][15:8] = memDqOut[15:8];
    end
  end

  // read drive and contention monitor on half-ns ticks
  initial begin
    #0.5;
    forever begin
      logic [DW-1:0] w;
      if (!rst && memDqOe && !memOeN && !memCeN && memWeN)
        check(1'b0, "R6", "bus driven while memory outputs on", 32'd1, 32'd0);
      if (!memCeN && !memOeN && memWeN) begin
        w = mem[memAddr];
        if ((($realtime - tAddr) >= TAA_NS) && (($realtime - tOe) >= TOE_NS))
          memDqIn = {memUbN ? 8'h00 : w[15:8], memLbN ? 8'h00 : w[7:0]};
        else
          memDqIn = ~w;
      end else begin
        memDqIn = '0;
      end
      #1;
    end
  end

  // ---------------- access task ----------------
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, output logic [DW-1:0] rd);
    int lat;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    check(reqReady == 1'b0, "R11", "ready low while busy", 32'(reqReady), 32'd0);
    if (wr) begin
      check({memCeN, memWeN, memOeN} == 3'b001, "R4", "write strobes ce/we/oe",
            32'({memCeN, memWeN, memOeN}), 32'b001);
      check({memUbN, memLbN} == ~be, "R5", "lane enables",
            32'({memUbN, memLbN}), 32'(~be));
    end else begin
      check({memCeN, memOeN, memWeN, memUbN, memLbN} == 5'b00100, "R2",
            "read strobes", 32'({memCeN, memOeN, memWeN, memUbN, memLbN}), 32'b00100);
    end
    while (!rspDone && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == (wr ? WR_LAT : RD_LAT), wr ? "R9" : "R3", "done latency",
          32'(lat), 32'(wr ? WR_LAT : RD_LAT));
    check(memCeN && !memDqOe && reqReady, "R8", "standby after access",
          32'({memCeN, memDqOe, reqReady}), 32'b101);
    rd = rspRdata;
    @(negedge clk);
    check(rspDone == 1'b0, "R10", "done lasts one clock", 32'(rspDone), 32'd0);
  endtask

  function automatic logic [DW-1:0] patA(input int a);
    return 16'(a * 40503 + 16'h1357);
  endfunction
  function automatic logic [DW-1:0] patB(input int a);
    return 16'(16'hC3A5 ^ (a * 769));
  endfunction

  initial begin : main
    logic [DW-1:0] rd, held;
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'hFFFF;
      expMem[i] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    check({memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe, rspDone, reqReady} == 8'b11111001,
          "R1", "reset state", 32'({memCeN, memOeN, memWeN, memUbN, memLbN, memDqOe, rspDone, reqReady}),
          32'b11111001);
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && memCeN && !memDqOe, "R1", "idle after reset",
          32'({reqReady, memCeN, memDqOe}), 32'b110);

    // full-word sweep
    for (int a = 0; a < NW; a++) begin
      access(1'b1, AW'(a), patA(a), 2'b11, rd);
      expMem[a] = patA(a);
    end
    for (int a = 0; a < NW; a++) begin
      access(1'b0, AW'(a), '0, 2'b00, rd);
      check(rd == expMem[a], "R2", "full word read", 32'(rd), 32'(expMem[a]));
    end

    // byte-lane sweep over all strobe combinations
    for (int a = 0; a < NW; a++) begin
      logic [1:0] be;
      be = 2'(a + (a >> 2));
      access(1'b1, AW'(a), patB(a), be, rd);
      if (be[0]) expMem[a][7:0]  = patB(a)[7:0];
      if (be[1]) expMem[a][15:8] = patB(a)[15:8];
    end
    for (int a = 0; a < NW; a++) begin
      access(1'b0, AW'(a), '0, 2'b11, rd);
      check(rd == expMem[a], "R5", "lane merged word", 32'(rd), 32'(expMem[a]));
    end

    // read data held across a following write
    access(1'b0, AW'(5), '0, 2'b00, held);
    access(1'b1, AW'(9), 16'h0F0F, 2'b11, rd);
    expMem[9] = 16'h0F0F;
    check(rspRdata == held, "R10", "read data held over write", 32'(rspRdata), 32'(held));

    // back-to-back with request already waiting (spacing monitored)
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(9); reqBe = 2'b11;
    @(negedge clk);
    while (!rspDone) @(negedge clk);
    check(rspRdata == 16'h0F0F, "R3", "back-to-back read 1", 32'(rspRdata), 32'h0F0F);
    reqAddr = AW'(5);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone) @(negedge clk);
    check(rspRdata == expMem[5], "R3", "back-to-back read 2", 32'(rspRdata), 32'(expMem[5]));

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule